// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block runs eight general-purpose pins from a small register bus. Five 8-bit registers are addressed by a 3-bit index. They set each pin's direction, its output level, whether an output pin floats, whether an input pin is inverted, and whether an input pin may raise the interrupt. The block drives the pin output values and output enables. It samples the pin inputs through a synchronizer and produces one combined interrupt line for the host.

The interrupt is latched when any enabled input pin shows an effective value of 1, meaning its synchronized value after the optional inversion. A pin can take part only if its direction bit marks it as an input. The inversion bit therefore decides whether the pin interrupts on a high or a low level. Every read of the level register returns the mixed live-input / stored-output view and also clears the latched interrupt. If the cause is still present, the interrupt returns on the following cycle.

Top module: `gp_port_ctl`

## Requirements
- R1: A synchronous active-high reset sets all five registers to 0x00 and clears the interrupt and read data. As a result, every pin is an output driven low with its enable asserted.
- R2: Register index 0 is direction, 1 is level, 2 is output float, 3 is input invert and 4 is interrupt enable. Writes take the data byte and bit n controls pin n. Reads of indices 0, 2, 3 and 4 return the stored byte. Reads of indices 5, 6 and 7 return 0x00.
- R3: Read data appears on bus_rdata one cycle after the cycle in which bus_rd is high, and holds until the next read. A write in the same cycle as a read does not affect that read's data.
- R4: A direction bit of 1 makes the pin an input, and an input pin's output enable is never asserted.
- R5: A float bit of 1 deasserts the output enable of that pin. For an output pin with float 0, the enable is asserted.
- R6: pin_out carries the level register, so writing 1 drives the pin high and writing 0 drives it low.
- R7: Reading the level register returns, for input pins, the pin value two clocks after it was sampled, XORed with the invert bit. For output pins, it returns the stored level bit.
- R8: An invert bit of 1 flips that pin's input before readback and interrupt detection. An invert bit of 0 passes the input unchanged.
- R9: The interrupt sets on the clock after any pin has enable=1, direction=input and an effective value of 1. An enable bit on an output pin has no effect on the interrupt.
- R10: Once set, the interrupt stays high until a level-register read. That read clears it on the same edge. If the cause persists, it sets again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_idx | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin input values |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables, 1 = drive |
| irq | output | 1 | Combined latched interrupt |

## Verification
The bench checks that a level read clears the interrupt while the cause is still present, and that the interrupt comes back on the very next edge. A design that skipped the clear, or that left it cleared, would show up on the next cycle. An interrupt enable set on an output pin driven high must keep irq low; a design that ignored the direction bit would raise it. The level-read view on mixed-direction bytes is compared against both sources. A swapped mux or a wrong synchronizer depth shows up as wrong bits or wrong timing. Reads that coincide with writes and reads of the unused indices are also covered.

// File: rtl/gp_port_pkg.sv
package gp_port_pkg;

    parameter int unsigned PIN_W = 8;
    parameter int unsigned IDX_W = 3;

    typedef logic [PIN_W-1:0] pins_t;

    typedef enum logic [IDX_W-1:0] {
        REG_DIR = 3'd0,
        REG_LVL = 3'd1,
        REG_HIZ = 3'd2,
        REG_INV = 3'd3,
        REG_IEN = 3'd4
    } reg_idx_e;

    typedef struct packed {
        pins_t dir;   // 1 = input
        pins_t lvl;   // output level
        pins_t hiz;   // 1 = float output
        pins_t inv;   // 1 = invert input
        pins_t ien;   // 1 = interrupt enable
    } cfg_t;

    function automatic pins_t level_view(cfg_t c, pins_t eff);
        return (c.dir & eff) | (~c.dir & c.lvl);
    endfunction

    function automatic pins_t read_mux(cfg_t c, pins_t view, logic [IDX_W-1:0] idx);
        pins_t r;
        case (idx)
            REG_DIR: r = c.dir;
            REG_LVL: r = view;
            REG_HIZ: r = c.hiz;
            REG_INV: r = c.inv;
            REG_IEN: r = c.ien;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/gp_regs.sv
module gp_regs
    import gp_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  pins_t            wdata,
    output cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (idx)
                REG_DIR: cfg.dir <= wdata;
                REG_LVL: cfg.lvl <= wdata;
                REG_HIZ: cfg.hiz <= wdata;
                REG_INV: cfg.inv <= wdata;
                REG_IEN: cfg.ien <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gp_irq.sv
module gp_irq
    import gp_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t cause,
    input  logic  clr,
    output logic  irq
);
    always_ff @(posedge clk) begin
        if (rst)       irq <= 1'b0;
        else if (clr)  irq <= 1'b0;
        else if (|cause) irq <= 1'b1;
    end
endmodule

// File: rtl/gp_port_ctl.sv
module gp_port_ctl
    import gp_port_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [PIN_W-1:0] bus_wdata,
    output logic [PIN_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe,
    output logic             irq
);
    cfg_t  cfg_q;
    pins_t sync_q;
    pins_t eff_in;
    pins_t cause_vec;
    logic  lvl_read;

    gp_sync #(.W(PIN_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(sync_q)
    );

    gp_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .idx(bus_idx),
        .wdata(bus_wdata), .cfg(cfg_q)
    );

    assign eff_in    = sync_q ^ cfg_q.inv;
    assign cause_vec = cfg_q.ien & cfg_q.dir & eff_in;
    assign lvl_read  = bus_rd && (bus_idx == REG_LVL);

    gp_irq u_irq (
        .clk(clk), .rst(rst), .cause(cause_vec), .clr(lvl_read), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= read_mux(cfg_q, level_view(cfg_q, eff_in), bus_idx);
    end

    assign pin_out = cfg_q.lvl;
    assign pin_oe  = ~(cfg_q.dir | cfg_q.hiz);
endmodule

// File: rtl/gp_port_chk.sv
module gp_port_chk
    import gp_port_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_rd,
    input logic [IDX_W-1:0] bus_idx,
    input logic             irq,
    input pins_t            pin_oe,
    input cfg_t             cfg,
    input pins_t            cause
);
    logic lvl_rd;
    assign lvl_rd = bus_rd && (bus_idx == REG_LVL);

    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst) |-> (cfg == '0) && !irq);

    p_input_undriven_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & cfg.dir) == '0);

    p_float_undriven_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & cfg.hiz) == '0);

    p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        lvl_rd |=> !irq);

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !lvl_rd) |=> irq);

    p_cause_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (|cause && !lvl_rd) |=> irq);

    p_rise_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|cause));
endmodule

bind gp_port_ctl gp_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_idx(bus_idx), .irq(irq),
    .pin_oe(pin_oe), .cfg(cfg_q), .cause(cause_vec)
);

// File: tb/sim_gp_port_ctl.sv
`timescale 1ns/1ps
module sim_gp_port_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_idx = '0;
    logic [7:0] bus_wdata = '0, pin_in = '0;
    logic [7:0] bus_rdata, pin_out, pin_oe;
    logic       irq;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    gp_port_ctl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] m_dir, m_lvl, m_hiz, m_inv, m_ien, m_rdata;
    logic       m_irq;
    logic [7:0] hist [$];
    bit         started = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_dir = 0; m_lvl = 0; m_hiz = 0; m_inv = 0; m_ien = 0;
            m_rdata = 0; m_irq = 0; hist = '{8'h00, 8'h00};
            started = 1;
        end else if (started) begin
            logic [7:0] eff;
            logic       cause;
            eff   = hist[1] ^ m_inv;
            cause = |(m_ien & m_dir & eff);
            if (bus_rd) begin
                case (bus_idx)
                    3'd0: m_rdata = m_dir;
                    3'd1: m_rdata = (m_dir & eff) | (~m_dir & m_lvl);
                    3'd2: m_rdata = m_hiz;
                    3'd3: m_rdata = m_inv;
                    3'd4: m_rdata = m_ien;
                    default: m_rdata = 8'h00;
                endcase
            end
            if (bus_rd && bus_idx == 3'd1) m_irq = 0;
            else if (cause) m_irq = 1;
            if (bus_wr) begin
                case (bus_idx)
                    3'd0: m_dir = bus_wdata;
                    3'd1: m_lvl = bus_wdata;
                    3'd2: m_hiz = bus_wdata;
                    3'd3: m_inv = bus_wdata;
                    3'd4: m_ien = bus_wdata;
                    default: ;
                endcase
            end
            void'(hist.pop_back());
            hist.push_front(pin_in);
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            check("R4/R5 pin_oe", pin_oe, ~(m_dir | m_hiz));
            check("R6 pin_out", pin_out, m_lvl);
            check("R3/R7 bus_rdata", bus_rdata, m_rdata);
            check("R9/R10 irq", {7'b0, irq}, {7'b0, m_irq});
        end
    end

    task automatic wr_reg(logic [2:0] i, logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_idx = i; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd_reg(logic [2:0] i);
        @(negedge clk); bus_rd = 1; bus_idx = i;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'hFF);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 8; i++) begin
            rd_reg(3'(i));
            check("R1 reg zero", bus_rdata, 8'h00);
        end
        // R2 map and readback
        wr_reg(3'd0, 8'h0F);
        wr_reg(3'd2, 8'h30);
        wr_reg(3'd1, 8'hA5);
        wr_reg(3'd5, 8'hFF);
        rd_reg(3'd0); check("R2 dir", bus_rdata, 8'h0F);
        rd_reg(3'd2); check("R2 hiz", bus_rdata, 8'h30);
        rd_reg(3'd5); check("R2 unused", bus_rdata, 8'h00);
        check("R4 R5 oe", pin_oe, 8'hC0);
        check("R6 out", pin_out, 8'hA5);
        // R8 invert, R7 mixed view
        wr_reg(3'd3, 8'h05);
        rd_reg(3'd3); check("R2 inv", bus_rdata, 8'h05);
        rd_reg(3'd1); check("R7 R8 level view", bus_rdata, 8'hA5);
        // R9 interrupt via inverted pin 0
        wr_reg(3'd4, 8'h03);
        @(negedge clk);
        check("R9 irq set", {7'b0, irq}, 8'h01);
        rd_reg(3'd1);
        check("R10 cleared", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R10 reassert", {7'b0, irq}, 8'h01);
        // R9 enable on output pin ignored
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd4, 8'h80);
        wr_reg(3'd1, 8'h80);
        pin_in = 8'hF0;
        repeat (3) @(negedge clk);
        rd_reg(3'd1);
        repeat (4) @(negedge clk);
        check("R9 output pin ignored", {7'b0, irq}, 8'h00);
        // R7 latency: pin 1 rises
        wr_reg(3'd4, 8'h02);
        pin_in = 8'h02;
        @(negedge clk); @(negedge clk);
        rd_reg(3'd1); check("R7 input seen", bus_rdata & 8'h0F, 8'h02);
        // R3 write during read
        @(negedge clk); bus_rd = 1; bus_wr = 1; bus_idx = 3'd2; bus_wdata = 8'h11;
        @(negedge clk); bus_rd = 0; bus_wr = 0;
        check("R3 old data", bus_rdata, 8'h30);
        // random traffic against the model
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            bus_wr    = ($urandom % 4) == 0;
            bus_rd    = ($urandom % 3) == 0;
            bus_idx   = 3'($urandom);
            bus_wdata = 8'($urandom);
            if (($urandom % 5) == 0) pin_in = 8'($urandom);
        end
        @(negedge clk); bus_wr = 0; bus_rd = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule